// File: doc/BRIEF.md
# Conditional-Sum Decimal Carry-Propagate Adder

This block turns a two-word redundant decimal result into one ordinary BCD number. One addend arrives with every digit biased by six (excess-6), the other as plain BCD digits. The block is purely combinational. Each digit position forms two candidate sums in parallel, one that assumes no incoming carry and one that assumes an incoming carry. Because of the bias, the binary carry out of each 4-bit sum is already the decimal carry. When that carry is clear, the candidate is corrected by subtracting six.

The carry into every digit is resolved by a logarithmic-depth parallel-prefix network. The network works on per-digit generate and propagate bits. A 2:1 multiplexer per digit then picks the candidate that matches the resolved carry. The output width equals the input width, set by a parameter to the 2d digits of a d-by-d decimal product. A final decimal carry is also brought out.

The block has no clock, no reset and no state. The usual state-machine layout of this code base does not apply to it. The naming, the layout and the assertion placement follow the house conventions.

Top module: `bcd_cs_adder`

## Requirements
- R1: For valid inputs, every output digit `sum_bcd[4i+3:4i]` equals (A_i + B_i + c_i) mod 10. Here c_i is the decimal carry into digit i, and c_0 = 0. Every output digit is in the range 0..9.
- R2: The carry out of digit i is 1 exactly when A_i + B_i + c_i is 10 or more. `carry_out` is this carry for the most significant digit. Taken together, {carry_out, sum_bcd} is the decimal value A + B.
- R3: Input encoding. Digit i of `a_xs6` sits at bits [4i+3:4i] and holds A_i + 6, so the codes run from 6 to 15. Digit i of `b_bcd` sits at the same bits and holds B_i in plain BCD, from 0 to 9. Each pair meets A_i + B_i <= 18. Digit 0 is the least significant.
- R4: A carry made in the least significant digit travels through a run of any length of digits whose pair sums are exactly 9. Each such digit then reads 0 and passes the carry on.
- R5: A digit pair that sums to 18 gives 8 with a carry when no carry comes in, and 9 with a carry when a carry comes in.
- R6: When every A_i and B_i is zero (codes 6 and 0), the output is all zero digits and `carry_out` is 0.
- R7: The outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_xs6 | input | 4*DIGITS | Addend A, excess-6 digits |
| b_bcd | input | 4*DIGITS | Addend B, plain BCD digits |
| sum_bcd | output | 4*DIGITS | Non-redundant BCD sum |
| carry_out | output | 1 | Decimal carry out of the top digit |

## Verification
The block holds no state, so a wrong internal value shows at the ports at once, in the same settle time as the input change.

- A fault in a digit cell's correction shows up as an output digit above 9, or off by six, at that position.
- A fault in a prefix node shows up as a wrong digit at every position above the faulty node. Carry chains of pair sums of 9 expose such faults across the full width.
- A wrong multiplexer select shows up as a digit off by one.

// File: rtl/bcd_cs_pkg.sv
package bcd_cs_pkg;
    localparam int DIGIT_W  = 4;
    localparam int XS_BIAS  = 6;
    localparam int DEC_BASE = 10;

    // Merge of two carry-select pairs {gen, prop}.
    // gen is the carry out with a cleared carry in; prop is the carry out
    // with a set carry in; prop is never below gen.
    function automatic logic [1:0] gp_merge(input logic [1:0] hi, input logic [1:0] lo);
        logic g_o;
        logic p_o;
        g_o = hi[1] | (hi[0] & lo[1]);
        p_o = hi[1] | (hi[0] & lo[0]);
        return {g_o, p_o};
    endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
    import bcd_cs_pkg::*;
(
    input  logic [DIGIT_W-1:0] a_code,
    input  logic [DIGIT_W-1:0] b_code,
    output logic [DIGIT_W-1:0] dig_c0,
    output logic [DIGIT_W-1:0] dig_c1,
    output logic               gen,
    output logic               prop
);
    localparam logic [DIGIT_W-1:0] FIX = DIGIT_W'(XS_BIAS);

    logic [DIGIT_W:0] raw_c0;
    logic [DIGIT_W:0] raw_c1;

    always_comb begin
        raw_c0 = {1'b0, a_code} + {1'b0, b_code};
        raw_c1 = {1'b0, a_code} + {1'b0, b_code} + {{DIGIT_W{1'b0}}, 1'b1};
    end

    always_comb begin
        gen    = raw_c0[DIGIT_W];
        prop   = raw_c1[DIGIT_W];
        dig_c0 = raw_c0[DIGIT_W] ? raw_c0[DIGIT_W-1:0] : raw_c0[DIGIT_W-1:0] - FIX;
        dig_c1 = raw_c1[DIGIT_W] ? raw_c1[DIGIT_W-1:0] : raw_c1[DIGIT_W-1:0] - FIX;
    end

    logic in_ok;
    always_comb begin
        in_ok = !$isunknown({a_code, b_code}) && (a_code >= FIX) && (b_code <= 4'd9)
                && ((a_code - FIX) + b_code <= 5'd18);
        if (in_ok) begin
            a_r1_cond_digit_bcd : assert (dig_c0 <= 4'd9 && dig_c1 <= 4'd9)
                else $error("conditional digit out of BCD range");
            a_r2_prop_covers_gen : assert (prop | !gen)
                else $error("carry with cin=0 but not with cin=1");
            a_r5_cond_step : assert ((dig_c0 == 4'd9) ? (dig_c1 == 4'd0 && prop)
                                                      : (dig_c1 == dig_c0 + 4'd1 && prop == gen))
                else $error("conditional paths disagree");
        end
    end
endmodule

// File: rtl/bcd_prefix_tree.sv
module bcd_prefix_tree
    import bcd_cs_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic [DIGITS-1:0] gen_in,
    input  logic [DIGITS-1:0] prop_in,
    output logic [DIGITS-1:0] grp_gen
);
    localparam int LEVELS = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    logic [DIGITS-1:0] g_lv [LEVELS+1];
    logic [DIGITS-1:0] p_lv [LEVELS+1];

    assign g_lv[0] = gen_in;
    assign p_lv[0] = prop_in;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int SPAN = 1 << lv;
        for (genvar i = 0; i < DIGITS; i++) begin : g_node
            if (i >= SPAN) begin : g_merge
                logic [1:0] mrg;
                assign mrg = gp_merge({g_lv[lv][i], p_lv[lv][i]},
                                      {g_lv[lv][i-SPAN], p_lv[lv][i-SPAN]});
                assign g_lv[lv+1][i] = mrg[1];
                assign p_lv[lv+1][i] = mrg[0];
            end else begin : g_pass
                assign g_lv[lv+1][i] = g_lv[lv][i];
                assign p_lv[lv+1][i] = p_lv[lv][i];
            end
        end
    end

    assign grp_gen = g_lv[LEVELS];
endmodule

// File: rtl/bcd_digit_select.sv
module bcd_digit_select
    import bcd_cs_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic [DIGIT_W*DIGITS-1:0] cand_c0,
    input  logic [DIGIT_W*DIGITS-1:0] cand_c1,
    input  logic [DIGITS-1:0]         carry_in,
    output logic [DIGIT_W*DIGITS-1:0] dig_out
);
    for (genvar i = 0; i < DIGITS; i++) begin : g_mux
        assign dig_out[DIGIT_W*i +: DIGIT_W] = carry_in[i] ? cand_c1[DIGIT_W*i +: DIGIT_W]
                                                           : cand_c0[DIGIT_W*i +: DIGIT_W];
    end
endmodule

// File: rtl/bcd_cs_adder.sv
module bcd_cs_adder
    import bcd_cs_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic [DIGIT_W*DIGITS-1:0] a_xs6,
    input  logic [DIGIT_W*DIGITS-1:0] b_bcd,
    output logic [DIGIT_W*DIGITS-1:0] sum_bcd,
    output logic                      carry_out
);
    localparam int WORD_W = DIGIT_W * DIGITS;

    logic [WORD_W-1:0] cand_c0;
    logic [WORD_W-1:0] cand_c1;
    logic [DIGITS-1:0] gen;
    logic [DIGITS-1:0] prop;
    logic [DIGITS-1:0] grp_gen;
    logic [DIGITS-1:0] dig_cin;

    for (genvar i = 0; i < DIGITS; i++) begin : g_cell
        bcd_digit_cell u_cell (
            .a_code (a_xs6[DIGIT_W*i +: DIGIT_W]),
            .b_code (b_bcd[DIGIT_W*i +: DIGIT_W]),
            .dig_c0 (cand_c0[DIGIT_W*i +: DIGIT_W]),
            .dig_c1 (cand_c1[DIGIT_W*i +: DIGIT_W]),
            .gen    (gen[i]),
            .prop   (prop[i])
        );
    end

    bcd_prefix_tree #(.DIGITS(DIGITS)) u_tree (
        .gen_in  (gen),
        .prop_in (prop),
        .grp_gen (grp_gen)
    );

    if (DIGITS > 1) begin : g_cin
        assign dig_cin = {grp_gen[DIGITS-2:0], 1'b0};
    end else begin : g_cin1
        assign dig_cin = 1'b0;
    end

    assign carry_out = grp_gen[DIGITS-1];

    bcd_digit_select #(.DIGITS(DIGITS)) u_sel (
        .cand_c0  (cand_c0),
        .cand_c1  (cand_c1),
        .carry_in (dig_cin),
        .dig_out  (sum_bcd)
    );

    // Checks against a ripple view of the same carries.
    always_comb begin
        if (!$isunknown({a_xs6, b_bcd})) begin
            for (int i = 0; i < DIGITS; i++) begin
                a_r1_out_digit_bcd : assert (sum_bcd[DIGIT_W*i +: DIGIT_W] <= 4'd9)
                    else $error("output digit %0d not BCD", i);
                if (i < DIGITS - 1) begin
                    a_r4_ripple_match : assert (dig_cin[i+1] == (gen[i] | (prop[i] & dig_cin[i])))
                        else $error("prefix carry into digit %0d wrong", i + 1);
                end
            end
            a_r2_top_carry : assert (carry_out == (gen[DIGITS-1] | (prop[DIGITS-1] & dig_cin[DIGITS-1])))
                else $error("top carry wrong");
        end
    end
endmodule

// File: tb/bcd_cs_adder_tb.sv
module bcd_cs_adder_tb;
    localparam int ND = 8;
    localparam int W  = 4 * ND;
    localparam longint MODV = 64'd100000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] a_xs6;
    logic [W-1:0] b_bcd;
    logic [W-1:0] sum_bcd;
    logic         carry_out;

    bcd_cs_adder #(.DIGITS(ND)) u_dut (
        .a_xs6     (a_xs6),
        .b_bcd     (b_bcd),
        .sum_bcd   (sum_bcd),
        .carry_out (carry_out)
    );

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    localparam logic [63:0] VEC [10] = '{
        64'h12345678_11111111,
        64'h99999999_00000001,
        64'h45454545_54545454,
        64'h99999999_99999999,
        64'h00000005_00000005,
        64'h54545454_45454546,
        64'h90000000_10000000,
        64'h08080808_01020304,
        64'h50505050_50505050,
        64'h00000009_00000009
    };

    function automatic longint to_int(input logic [W-1:0] v);
        longint r = 0;
        for (int i = ND - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [W-1:0] to_bcd(input longint v);
        logic [W-1:0] r = '0;
        longint t = v;
        for (int i = 0; i < ND; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] bias6(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < ND; i++) r[4*i +: 4] = v[4*i +: 4] + 4'd6;
        return r;
    endfunction

    task automatic compare(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        longint tot = to_int(a) + to_int(b);
        logic [W-1:0] es = to_bcd(tot % MODV);
        logic ec = (tot >= MODV);
        nvec++;
        if (sum_bcd !== es || carry_out !== ec) begin
            nfail++;
            $display("FAIL %s: a=%h b=%h actual sum=%h c=%b expected sum=%h c=%b",
                     req, a, b, sum_bcd, carry_out, es, ec);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        @(negedge clk);
        a_xs6 = bias6(a);
        b_bcd = b;
        #1;
        compare(a, b, req);
    endtask

    initial begin
        a_xs6 = bias6('0);
        b_bcd = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R6: zero operands give zero
        @(negedge clk);
        compare('0, '0, "R6 zero operands");

        // R1 R2: table walk
        foreach (VEC[k]) apply(VEC[k][63:32], VEC[k][31:0], "R1/R2 table");

        // R4: carry from digit 0 through a run of nines
        apply(32'h45454545, 32'h54545455, "R4 full chain");
        apply(32'h00045454, 32'h00054546, "R4 partial chain");
        // R5: pair sum 18 with and without carry in
        apply(32'h00000090, 32'h00000090, "R5 eighteen no cin");
        apply(32'h00000099, 32'h00000091, "R5 eighteen with cin");
        // R2: pair sum 10 carries, 9 does not
        apply(32'h00000046, 32'h00000004, "R2 ten");
        apply(32'h00000045, 32'h00000004, "R2 nine");

        // R7: change between edges, observe before the next edge
        @(posedge clk);
        #2;
        a_xs6 = bias6(32'h77777777);
        b_bcd = 32'h33333333;
        #1;
        compare(32'h77777777, 32'h33333333, "R7 no clock");

        // R1 R3: random valid digit pairs
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            for (int i = 0; i < ND; i++) begin
                ra[4*i +: 4] = 4'($urandom_range(0, 9));
                rb[4*i +: 4] = 4'($urandom_range(0, 9));
            end
            apply(ra, rb, "R1/R3 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule